// File: doc/BRIEF.md
# Wake-up Frame Validator

The validator runs after an external detector has recognised a wake-up header. It takes the bit period measured over that header and, when rate checking is on, accepts the header only if that period lies close enough to a programmed period. It then walks the recovered bit stream that follows. It compares an address field of programmable length against a programmed address. It gathers a data field of fixed or variable length and watches for runs of equal bits that a valid frame cannot contain.

A frame that passes produces a one-cycle wake event and presents its data bits. A frame that fails produces a one-cycle restart request, so that the header search resumes while the listen window is still open. In debug mode it also sets a sticky error flag that names the reason. When the listen window closes, the block drops whatever it was doing and waits for the next header.

Top module: `wkup_frame_chk`

## Requirements
- R1: With `cfg_rate_chk` high, a header is accepted only if the absolute difference between `hdr_period` and `cfg_exp_period` is at most `cfg_tol`, so a difference equal to the tolerance passes. With `cfg_rate_chk` low, every header is accepted.
- R2: A header that is rejected on rate gives a one-cycle `restart_req` and no `wake_evt`. The next header is then processed normally.
- R3: An accepted header with `cfg_addr_len` and `cfg_data_len` both zero is a complete frame. `wake_evt` is high in the second cycle after the cycle in which `hdr_valid` is sampled, and `wake_data` is zero.
- R4: The first `cfg_addr_len` bits after the header are compared, first bit first, with `cfg_addr[cfg_addr_len-1:0]`, starting at its most significant bit. A mismatching bit aborts the frame with `restart_req`.
- R5: Four equal consecutive bits anywhere in the bits following the header abort the frame with `restart_req`. At a single bit, the checks take this priority: stuffing, then address, then completion, then missing stop.
- R6: With `cfg_var_len` low, the frame completes on bit number `cfg_addr_len + cfg_data_len`. `wake_evt` pulses and `wake_data` holds the data bits right-aligned, with the earliest data bit most significant.
- R7: With `cfg_var_len` high, the frame completes when the last four data bits equal `cfg_stop_pat`, where the earliest of the four is bit 3. `wake_data` then holds the data bits that precede the stop field, right-aligned. If the data count reaches `cfg_data_len` with no match, the frame aborts with `restart_req`.
- R8: `err_flags` sets bit 0 on a rate reject, bit 1 on an address mismatch, bit 2 on a stuffing error and bit 3 on a missing stop, and only while `cfg_dbg_en` is high. Each flag stays set until `err_clr`.
- R9: While `win_active` is low, the block is idle. It ignores headers and bits, and it gives no `wake_evt` and no `restart_req`.
- R10: A new `hdr_valid` during reception restarts the field bit count at zero.
- R11: After reset, `wake_evt`, `restart_req`, `wake_data` and `err_flags` are all zero.
- R12: With `cfg_addr_len` zero and `cfg_data_len` equal to the address width, the received address bits appear in `wake_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_active | input | 1 | Listen window open |
| hdr_valid | input | 1 | One-cycle pulse at header end |
| hdr_period | input | PER_W | Bit period measured on the header |
| bit_stb | input | 1 | Recovered bit strobe |
| bit_in | input | 1 | Recovered bit value |
| cfg_rate_chk | input | 1 | Rate check enable |
| cfg_exp_period | input | PER_W | Expected bit period |
| cfg_tol | input | PER_W | Allowed period deviation |
| cfg_addr | input | ADDR_W | Expected address |
| cfg_addr_len | input | ALEN_W | Address length in bits |
| cfg_data_len | input | DLEN_W | Data length, or its maximum in variable mode |
| cfg_var_len | input | 1 | Variable length mode |
| cfg_stop_pat | input | 4 | Stop field pattern |
| cfg_dbg_en | input | 1 | Error flag reporting enable |
| err_clr | input | 1 | Clears all error flags |
| wake_evt | output | 1 | Valid frame pulse |
| wake_data | output | DATA_W | Captured data bits |
| restart_req | output | 1 | Frame rejected, resume header search |
| err_flags | output | 4 | Sticky error flags |

## Verification
The assertions assume that the configuration inputs stay fixed while a frame is in progress, that the lengths stay within `ADDR_W` and `DATA_W`, and that `bit_stb` never falls in the same cycle as `hdr_valid`. The bench changes the configuration only between frames, picks lengths from the legal ranges, and spaces the strobes three cycles apart after each header. It also drops `win_active` and issues a second header mid-frame, so both paths are exercised.

// File: rtl/wkup_pkg.sv
// Shared types for the wake-up frame validator.
// Assumes nothing beyond the parameters of the modules that import it.
package wkup_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_RATE   = 2'd1,
        ST_RECV   = 2'd2
    } wk_state_e;

    typedef enum logic [2:0] {
        OUT_NONE   = 3'd0,
        OUT_WAKE   = 3'd1,
        OUT_RATE   = 3'd2,
        OUT_ADDR   = 3'd3,
        OUT_STUFF  = 3'd4,
        OUT_NOSTOP = 3'd5
    } wk_outcome_e;

    localparam int NUM_ERR    = 4;
    localparam int ERR_RATE   = 0;
    localparam int ERR_ADDR   = 1;
    localparam int ERR_STUFF  = 2;
    localparam int ERR_NOSTOP = 3;
    localparam int STOP_W     = 4;

endpackage

// File: rtl/wkup_rate_cmp.sv
// Combinational bit-period comparator.
// Passes when |meas - expect| <= tol, or when checking is disabled.
// Assumes unsigned period counts of equal width.
module wkup_rate_cmp #(
    parameter int PER_W = 16
) (
    input  logic [PER_W-1:0] meas,
    input  logic [PER_W-1:0] expect_per,
    input  logic [PER_W-1:0] tol,
    input  logic             chk_en,
    output logic             rate_ok
);
    logic [PER_W-1:0] diff;

    // absolute difference, then the window test
    always_comb begin
        diff    = (meas >= expect_per) ? (meas - expect_per) : (expect_per - meas);
        rate_ok = !chk_en || (diff <= tol);
    end
endmodule

// File: rtl/wkup_stuff_run.sv
// Tracks the run of equal bits in the received stream.
// Flags the strobe that would make the fourth equal bit in a row.
// Assumes clr arrives with each header, before any strobe of that frame.
module wkup_stuff_run (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic stb,
    input  logic bit_in,
    output logic stuff_hit
);
    logic [1:0] run_q;
    logic       last_q;
    logic       have_q;
    logic       same;

    // compare the new bit against the previous one
    always_comb begin
        same      = have_q && (bit_in == last_q);
        stuff_hit = stb && same && (run_q == 2'd3);
    end

    // run length register, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q  <= 2'd0;
            last_q <= 1'b0;
            have_q <= 1'b0;
        end else if (stb) begin
            run_q  <= same ? ((run_q == 2'd3) ? 2'd3 : run_q + 2'd1) : 2'd1;
            last_q <= bit_in;
            have_q <= 1'b1;
        end
    end
endmodule

// File: rtl/wkup_field_trk.sv
// Counts the bits after a header, splits them into address and data
// fields, compares the address most significant bit first, and shifts
// the data bits in. Reports the completion conditions for the strobe
// now presented. Assumes the lengths stay within ADDR_W and DATA_W.
module wkup_field_trk
    import wkup_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int ALEN_W = $clog2(ADDR_W + 1),
    localparam int DLEN_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              stb,
    input  logic              bit_in,
    input  logic [ADDR_W-1:0] exp_addr,
    input  logic [ALEN_W-1:0] addr_len,
    input  logic [DLEN_W-1:0] data_len,
    input  logic              var_len,
    input  logic [STOP_W-1:0] stop_pat,
    output logic              addr_bad,
    output logic              fixed_done,
    output logic              stop_hit,
    output logic              len_end,
    output logic [DATA_W-1:0] data_fixed,
    output logic [DATA_W-1:0] data_var
);
    localparam int CNT_W = $clog2(ADDR_W + DATA_W + 2);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] dsh_q;
    logic [DATA_W-1:0] dsh_nxt;
    logic              in_addr;
    logic              exp_bit;
    int                alen;
    int                dlen;
    int                pos;
    int                idx;
    int                total;
    int                dcnt;

    // decode the field position of the bit on the strobe
    always_comb begin
        alen    = int'(addr_len);
        dlen    = int'(data_len);
        pos     = int'(cnt_q);
        in_addr = pos < alen;
        idx     = alen - 1 - pos;
        exp_bit = 1'b0;
        for (int k = 0; k < ADDR_W; k++) begin
            if (k == idx) exp_bit = exp_addr[k];
        end
        addr_bad   = in_addr && (bit_in != exp_bit);
        dsh_nxt    = in_addr ? dsh_q : {dsh_q[DATA_W-2:0], bit_in};
        total      = pos + 1;
        dcnt       = total - alen;
        fixed_done = !var_len && (total == alen + dlen);
        stop_hit   = var_len && !in_addr && (dcnt >= STOP_W)
                     && (dsh_nxt[STOP_W-1:0] == stop_pat);
        len_end    = total >= alen + dlen;
        data_fixed = dsh_nxt;
        data_var   = dsh_nxt >> STOP_W;
    end

    // bit counter and data shift register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            dsh_q <= '0;
        end else if (stb) begin
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            dsh_q <= dsh_nxt;
        end
    end
endmodule

// File: rtl/wkup_err_bank.sv
// Sticky error flags: one per cause, set by a pulse, cleared by a strobe.
// A set in the same cycle as a clear wins. Assumes single-cycle set pulses.
module wkup_err_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // one sticky bit
        always_ff @(posedge clk) begin
            if (!rst_n) flags[g] <= 1'b0;
            else        flags[g] <= (flags[g] && !clr) || set[g];
        end
    end
endmodule

// File: rtl/wkup_frame_chk.sv
// Wake-up frame validator top. Sequences the rate check, the address and
// data fields, and the framing checks after each header pulse. Decides one
// outcome per cycle, and registers it into the wake, restart and error outputs.
// Assumes the configuration is stable during a frame and that bit_stb never
// coincides with hdr_valid.
module wkup_frame_chk
    import wkup_pkg::*;
#(
    parameter int PER_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int ALEN_W = $clog2(ADDR_W + 1),
    localparam int DLEN_W = $clog2(DATA_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_active,
    input  logic               hdr_valid,
    input  logic [PER_W-1:0]   hdr_period,
    input  logic               bit_stb,
    input  logic               bit_in,
    input  logic               cfg_rate_chk,
    input  logic [PER_W-1:0]   cfg_exp_period,
    input  logic [PER_W-1:0]   cfg_tol,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [ALEN_W-1:0]  cfg_addr_len,
    input  logic [DLEN_W-1:0]  cfg_data_len,
    input  logic               cfg_var_len,
    input  logic [STOP_W-1:0]  cfg_stop_pat,
    input  logic               cfg_dbg_en,
    input  logic               err_clr,
    output logic               wake_evt,
    output logic [DATA_W-1:0]  wake_data,
    output logic               restart_req,
    output logic [NUM_ERR-1:0] err_flags
);
    wk_state_e         state_q;
    wk_outcome_e       outcome;
    logic [PER_W-1:0]  per_q;
    logic              rate_ok;
    logic              fresh_hdr;
    logic              rx_stb;
    logic              stuff_hit;
    logic              addr_bad;
    logic              fixed_done;
    logic              stop_hit;
    logic              len_end;
    logic [DATA_W-1:0] data_fixed;
    logic [DATA_W-1:0] data_var;
    logic [NUM_ERR-1:0] err_set;

    // qualify headers and strobes by the window and the state
    always_comb begin
        fresh_hdr = win_active && hdr_valid;
        rx_stb    = win_active && !hdr_valid && bit_stb && (state_q == ST_RECV);
    end

    wkup_rate_cmp #(.PER_W(PER_W)) u_rate (
        .meas       (per_q),
        .expect_per (cfg_exp_period),
        .tol        (cfg_tol),
        .chk_en     (cfg_rate_chk),
        .rate_ok    (rate_ok)
    );

    wkup_stuff_run u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fresh_hdr),
        .stb       (rx_stb),
        .bit_in    (bit_in),
        .stuff_hit (stuff_hit)
    );

    wkup_field_trk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (fresh_hdr),
        .stb        (rx_stb),
        .bit_in     (bit_in),
        .exp_addr   (cfg_addr),
        .addr_len   (cfg_addr_len),
        .data_len   (cfg_data_len),
        .var_len    (cfg_var_len),
        .stop_pat   (cfg_stop_pat),
        .addr_bad   (addr_bad),
        .fixed_done (fixed_done),
        .stop_hit   (stop_hit),
        .len_end    (len_end),
        .data_fixed (data_fixed),
        .data_var   (data_var)
    );

    // pick one outcome for this cycle by priority
    always_comb begin
        outcome = OUT_NONE;
        if (win_active && !hdr_valid) begin
            case (state_q)
                ST_RATE: begin
                    if (!rate_ok)
                        outcome = OUT_RATE;
                    else if (cfg_addr_len == '0 && cfg_data_len == '0)
                        outcome = OUT_WAKE;
                end
                ST_RECV: begin
                    if (rx_stb) begin
                        if (stuff_hit)                    outcome = OUT_STUFF;
                        else if (addr_bad)                outcome = OUT_ADDR;
                        else if (fixed_done || stop_hit)  outcome = OUT_WAKE;
                        else if (cfg_var_len && len_end)  outcome = OUT_NOSTOP;
                    end
                end
                default: outcome = OUT_NONE;
            endcase
        end
    end

    // map rejections onto error flag set pulses when debug is on
    always_comb begin
        err_set = '0;
        if (cfg_dbg_en) begin
            err_set[ERR_RATE]   = (outcome == OUT_RATE);
            err_set[ERR_ADDR]   = (outcome == OUT_ADDR);
            err_set[ERR_STUFF]  = (outcome == OUT_STUFF);
            err_set[ERR_NOSTOP] = (outcome == OUT_NOSTOP);
        end
    end

    wkup_err_bank #(.N(NUM_ERR)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (err_clr),
        .set   (err_set),
        .flags (err_flags)
    );

    // frame state machine and registered event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_SEARCH;
            per_q       <= '0;
            wake_evt    <= 1'b0;
            restart_req <= 1'b0;
            wake_data   <= '0;
        end else begin
            wake_evt    <= (outcome == OUT_WAKE);
            restart_req <= (outcome == OUT_RATE) || (outcome == OUT_ADDR)
                           || (outcome == OUT_STUFF) || (outcome == OUT_NOSTOP);
            if (outcome == OUT_WAKE)
                wake_data <= (state_q == ST_RATE) ? '0
                           : (cfg_var_len ? data_var : data_fixed);
            if (!win_active) begin
                state_q <= ST_SEARCH;
            end else if (hdr_valid) begin
                state_q <= ST_RATE;
                per_q   <= hdr_period;
            end else if (outcome != OUT_NONE) begin
                state_q <= ST_SEARCH;
            end else if (state_q == ST_RATE) begin
                state_q <= ST_RECV;
            end
        end
    end
endmodule

// File: rtl/wkup_frame_chk_sva.sv
// Property checker for the wake-up frame validator, bound to its top.
// Watches only ports; assumes the input rules listed in the brief.
module wkup_frame_chk_sva #(
    parameter int NUM_ERR = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               win_active,
    input logic               hdr_valid,
    input logic               err_clr,
    input logic               cfg_dbg_en,
    input logic               wake_evt,
    input logic               restart_req,
    input logic [NUM_ERR-1:0] err_flags
);
    // R9
    win_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_active |=> (!wake_evt && !restart_req));

    // R10
    hdr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_active && hdr_valid) |=> (!wake_evt && !restart_req));

    // R2
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_evt && restart_req));

    // R6
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R8
    err_dbg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dbg_en && !err_clr) |=> (err_flags == $past(err_flags)));

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags != $past(err_flags) && !$past(err_clr)) |-> restart_req);
endmodule

bind wkup_frame_chk wkup_frame_chk_sva #(.NUM_ERR(4)) u_wkup_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_active  (win_active),
    .hdr_valid   (hdr_valid),
    .err_clr     (err_clr),
    .cfg_dbg_en  (cfg_dbg_en),
    .wake_evt    (wake_evt),
    .restart_req (restart_req),
    .err_flags   (err_flags)
);

// File: tb/test_wkup_frame_chk.sv
// Bench for the wake-up frame validator: directed corners, then random frames
// checked against a reference model written from the requirements.
module test_wkup_frame_chk;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        win_active = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [15:0] hdr_period = '0;
    logic        bit_stb = 1'b0;
    logic        bit_in = 1'b0;
    logic        cfg_rate_chk = 1'b1;
    logic [15:0] cfg_exp_period = 16'd100;
    logic [15:0] cfg_tol = 16'd10;
    logic [7:0]  cfg_addr = 8'hA5;
    logic [3:0]  cfg_addr_len = '0;
    logic [4:0]  cfg_data_len = '0;
    logic        cfg_var_len = 1'b0;
    logic [3:0]  cfg_stop_pat = 4'b0110;
    logic        cfg_dbg_en = 1'b1;
    logic        err_clr = 1'b0;
    logic        wake_evt;
    logic [15:0] wake_data;
    logic        restart_req;
    logic [3:0]  err_flags;

    int total = 0;
    int bad = 0;
    int wake_cnt = 0;
    int rst_cnt = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    wkup_frame_chk i_wkup_frame_chk (
        .clk(clk), .rst_n(rst_n), .win_active(win_active), .hdr_valid(hdr_valid),
        .hdr_period(hdr_period), .bit_stb(bit_stb), .bit_in(bit_in),
        .cfg_rate_chk(cfg_rate_chk), .cfg_exp_period(cfg_exp_period), .cfg_tol(cfg_tol),
        .cfg_addr(cfg_addr), .cfg_addr_len(cfg_addr_len), .cfg_data_len(cfg_data_len),
        .cfg_var_len(cfg_var_len), .cfg_stop_pat(cfg_stop_pat), .cfg_dbg_en(cfg_dbg_en),
        .err_clr(err_clr), .wake_evt(wake_evt), .wake_data(wake_data),
        .restart_req(restart_req), .err_flags(err_flags)
    );

    // count output pulses away from the active edge
    always @(negedge clk) begin
        if (wake_evt) wake_cnt++;
        if (restart_req) rst_cnt++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model: 0 none, 1 wake, 2 rate, 3 address, 4 stuffing, 5 no stop
    function automatic void model(input logic [63:0] msg, input int n,
                                  input logic [15:0] per, output int kind,
                                  output logic [15:0] data);
        int al = int'(cfg_addr_len);
        int dl = int'(cfg_data_len);
        int run = 0;
        logic last = 1'b0;
        logic [15:0] dsh = '0;
        int diff = int'(per) - int'(cfg_exp_period);
        if (diff < 0) diff = -diff;
        kind = 0;
        data = '0;
        if (cfg_rate_chk && diff > int'(cfg_tol)) begin kind = 2; return; end
        if (al == 0 && dl == 0) begin kind = 1; return; end
        for (int i = 0; i < n; i++) begin
            logic b = msg[n-1-i];
            run = (i > 0 && b == last) ? run + 1 : 1;
            last = b;
            if (run >= 4) begin kind = 4; return; end
            if (i < al && b != cfg_addr[al-1-i]) begin kind = 3; return; end
            if (i >= al) dsh = {dsh[14:0], b};
            if (!cfg_var_len && i + 1 == al + dl) begin kind = 1; data = dsh; return; end
            if (cfg_var_len && i >= al && i + 1 - al >= 4 && dsh[3:0] == cfg_stop_pat) begin
                kind = 1; data = dsh >> 4; return;
            end
            if (cfg_var_len && i + 1 >= al + dl) begin kind = 5; return; end
        end
    endfunction

    task automatic send_hdr(input logic [15:0] per);
        @(negedge clk); hdr_valid = 1'b1; hdr_period = per;
        @(negedge clk); hdr_valid = 1'b0;
    endtask

    task automatic send_bits(input logic [63:0] msg, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_stb = 1'b1; bit_in = msg[n-1-i];
            @(negedge clk); bit_stb = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clear_err();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    // one complete frame checked against the model
    task automatic run_msg(input logic [63:0] msg, input int n, input logic [15:0] per,
                           input string req);
        int kind;
        logic [15:0] data;
        int w0, r0;
        logic [3:0] ef;
        model(msg, n, per, kind, data);
        clear_err();
        w0 = wake_cnt; r0 = rst_cnt;
        send_hdr(per);
        send_bits(msg, n);
        repeat (3) @(negedge clk);
        chk((wake_cnt - w0) == (kind == 1 ? 1 : 0), {req, " wake count"}, wake_cnt - w0, kind == 1);
        chk((rst_cnt - r0) == (kind >= 2 ? 1 : 0), {req, " restart count"}, rst_cnt - r0, kind >= 2);
        if (kind == 1) chk(wake_data == data, {req, " data"}, wake_data, data);
        ef = '0;
        if (cfg_dbg_en && kind >= 2) ef[kind-2] = 1'b1;
        chk(err_flags == ef, {req, " R8 flags"}, err_flags, ef);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w0, r0;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!wake_evt && !restart_req && wake_data == 0 && err_flags == 0, "R11 reset", 0, 0);
        rst_n = 1'b1; win_active = 1'b1;
        @(negedge clk);

        // R3 header-only wake at exactly the tolerance edge, with exact timing (R1)
        w0 = wake_cnt;
        send_hdr(16'd110);
        @(negedge clk);
        chk(wake_evt == 1'b1, "R3 wake timing", wake_evt, 1);
        chk(wake_data == 0, "R3 data zero", wake_data, 0);
        // R1 one past the tolerance rejects; R2 restart
        run_msg(64'd0, 0, 16'd111, "R1 R2 rate reject");
        run_msg(64'd0, 0, 16'd89, "R1 rate low reject");
        cfg_rate_chk = 1'b0;
        run_msg(64'd0, 0, 16'd500, "R1 check disabled");
        cfg_rate_chk = 1'b1;
        // R2 search resumes: a good header after a reject
        run_msg(64'd0, 0, 16'd95, "R2 next header");

        // R12 address caught as data
        cfg_addr_len = 4'd0; cfg_data_len = 5'd8;
        run_msg(64'hB2, 8, 16'd100, "R12 capture");
        // R6 fixed frame, R4 address match
        cfg_addr = 8'hA5; cfg_addr_len = 4'd8; cfg_data_len = 5'd6;
        run_msg({50'd0, 8'hA5, 6'b101101}, 14, 16'd100, "R6 fixed frame");
        // R4 address mismatch at the last bit
        run_msg({50'd0, 8'hA4, 6'b101101}, 14, 16'd100, "R4 addr mismatch");
        // R5 run of four crossing the address/data boundary (A5 ends in 1)
        run_msg({50'd0, 8'hA5, 6'b111010}, 14, 16'd100, "R5 boundary stuff");
        // R7 stop found, and stop missing
        cfg_var_len = 1'b1; cfg_data_len = 5'd12;
        run_msg({46'd0, 8'hA5, 6'b010010, 4'b0110}, 18, 16'd100, "R7 stop found");
        run_msg({44'd0, 8'hA5, 12'b010010101001}, 20, 16'd100, "R7 no stop");
        cfg_var_len = 1'b0;
        // R8 debug off: reject but no flag
        cfg_dbg_en = 1'b0;
        run_msg({50'd0, 8'hA4, 6'b101101}, 14, 16'd100, "R8 dbg off");
        cfg_dbg_en = 1'b1;
        // R8 sticky across a good frame, then cleared
        send_hdr(16'd130); repeat (3) @(negedge clk);
        send_hdr(16'd100); send_bits({50'd0, 8'hA5, 6'b101101}, 14); repeat (3) @(negedge clk);
        chk(err_flags == 4'b0001, "R8 sticky", err_flags, 1);
        clear_err();
        chk(err_flags == 0, "R8 clear", err_flags, 0);

        // R9 window drop mid-frame: remaining bits ignored
        w0 = wake_cnt; r0 = rst_cnt;
        send_hdr(16'd100);
        send_bits({58'd0, 6'b101001}, 6);
        @(negedge clk); win_active = 1'b0;
        send_hdr(16'd100);
        send_bits({56'd0, 8'b01101101}, 8);
        @(negedge clk); win_active = 1'b1;
        repeat (3) @(negedge clk);
        chk(wake_cnt == w0 && rst_cnt == r0, "R9 idle when closed", wake_cnt - w0, 0);
        run_msg({50'd0, 8'hA5, 6'b010011}, 14, 16'd100, "R9 after reopen");

        // R10 new header restarts the count
        send_hdr(16'd100);
        send_bits({59'd0, 5'b10100}, 5);
        run_msg({50'd0, 8'hA5, 6'b110100}, 14, 16'd100, "R10 restart count");

        // random frames
        for (int t = 0; t < 400; t++) begin
            logic [63:0] msg = '0;
            int n, al, dl, k;
            logic [15:0] per;
            logic safe;
            cfg_rate_chk = ($urandom % 4) != 0;
            cfg_dbg_en   = ($urandom % 5) != 0;
            cfg_var_len  = $urandom % 2;
            cfg_stop_pat = (($urandom % 2) != 0) ? 4'b0110 : 4'b1001;
            cfg_addr     = 8'($urandom);
            al = $urandom % 9;
            dl = $urandom % 17;
            cfg_addr_len = 4'(al);
            cfg_data_len = 5'(dl);
            per = 16'(85 + ($urandom % 31));
            safe = ($urandom % 3) != 0;
            n = al + dl + 2;
            for (int i = 0; i < n; i++) begin
                logic b = 1'($urandom);
                if (i < al && ($urandom % 5) != 0) b = cfg_addr[al-1-i];
                if (safe && i >= 3 && msg[2:0] == {3{msg[0]}}) b = ~msg[0];
                msg = {msg[62:0], b};
            end
            if (cfg_var_len && dl >= 4 && ($urandom % 3) != 0) begin
                k = $urandom % (dl - 3);
                for (int j = 0; j < 4; j++) msg[n-1-(al+k+j)] = cfg_stop_pat[3-j];
            end
            run_msg(msg, n, per, (t % 2) ? "R4 R5 R6 random" : "R1 R7 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule